// File: doc/BRIEF.md
# Sampling Converter Control Sequencer

This block is the digital control section that sits beside a 12-bit sampling converter core. It takes the chip-select, read, output-enable, sample-request and standby pins, passes each one through a synchroniser into the single clock domain, and runs every conversion. It drives an end-of-conversion flag and an active-low interrupt. It captures the two-way channel choice for the input multiplexer and latches each result into an output register that feeds a three-state bus. The bus is modelled here as a data word plus a drive-enable.

The analog core is not part of this block. The result code is offered on an input, and the sequencer copies it in the cycle the conversion ends. The delay before a conversion begins and the length of the conversion are parameters counted in clock cycles.

The same logic supports two ways of working. In interrupt mode a host waits for the interrupt and then reads. In streaming mode select and read are held low and enable is held high, so the bus always shows the newest finished result.

Top module: `sadc_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it falls, eoc is 1, int_n is 1, dout_en is 0, dout is 0, mux_ch is 0 and overrun is 0.
- R2: A conversion starts only on a 1-to-0 change of smp_req_n seen while cs_n is low. A falling edge seen while cs_n is high has no effect on eoc. Every control pin passes through SYNC_STAGES flip-flops. eoc falls on clock edge SYNC_STAGES+1+START_DLY, counting the first edge after the pin change as edge 1.
- R3: eoc stays low for exactly CONV_CYC cycles and then rises. In the same cycle, dout loads the value on core_code.
- R4: int_n falls in the cycle eoc rises at the end of a conversion. It returns high on the edge after cs_n and rd_n are both seen low, and it stays high while they stay low, even when a conversion completes.
- R5: dout_en is 1 only when oe is 1, cs_n is 0, rd_n is 0 and eoc is 1, using the synchronised pins.
- R6: dout keeps the previous result until the next conversion completes. With cs_n=0, rd_n=0 and oe=1 held, the bus carries the old result and then switches to the new one.
- R7: mux_ch copies ch_sel in the cycle eoc falls and does not change while eoc is low. ch_sel=0 selects channel one (mux_ch=0) and ch_sel=1 selects channel two (mux_ch=1).
- R8: While stby_n is low, sample requests are ignored and eoc is held at 1. A conversion in progress is dropped, and neither dout nor int_n changes.
- R9: A sample request accepted under R2 while a conversion is pending or running is ignored, and it sets overrun. overrun then stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low; gates read, enable and sample request |
| rd_n | input | 1 | Read strobe, active low |
| oe | input | 1 | Output enable, active high |
| smp_req_n | input | 1 | Sample request; a falling edge starts a conversion |
| stby_n | input | 1 | Low puts the block in standby |
| ch_sel | input | 1 | Channel choice for the input multiplexer |
| core_code | input | CODE_W | Result code from the converter core |
| eoc | output | 1 | End of conversion; low while converting |
| int_n | output | 1 | Interrupt, active low |
| dout | output | CODE_W | Output register contents |
| dout_en | output | 1 | Bus drive enable; when 0 the bus is high-impedance |
| mux_ch | output | 1 | Latched multiplexer channel |
| overrun | output | 1 | Sticky flag for a request that arrived while busy |

## Verification
Every result is due a fixed number of edges after the pin change that causes it. The eoc fall comes SYNC_STAGES+1+START_DLY edges later, and its rise, the dout load and the int_n fall come CONV_CYC edges after that. An int_n clear comes SYNC_STAGES+1 edges after the read pins go low, and dout_en follows the pins after SYNC_STAGES edges. The bench drives pins just after a rising edge and keeps a behavioural model that replays pin history through a delay queue of the same depth. It compares every output on every falling edge, so each result is checked in exactly the cycle it is due and in every cycle before and after.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_CONV = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic cs_n;
        logic rd_n;
        logic oe;
        logic smp_n;
        logic stby_n;
        logic sel;
    } ctl_pins_t;

    localparam ctl_pins_t PINS_IDLE = '{cs_n: 1'b1, rd_n: 1'b1, oe: 1'b0,
                                        smp_n: 1'b1, stby_n: 1'b1, sel: 1'b0};

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sadc_sync.sv
module sadc_sync
    import sadc_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  ctl_pins_t raw,
    output ctl_pins_t synced
);
    ctl_pins_t stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= PINS_IDLE;
        end else begin
            stage_q[0] <= raw;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign synced = stage_q[STAGES-1];
endmodule

// File: rtl/sadc_seq.sv
module sadc_seq
    import sadc_pkg::*;
#(
    parameter int START_DLY = 3,
    parameter int CONV_CYC  = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_s,
    input  logic smp_s,
    input  logic stby_s,
    input  logic sel_s,
    output logic eoc,
    output logic done,
    output logic mux_ch,
    output logic overrun
);
    localparam int CW = $clog2(max_of(START_DLY, CONV_CYC) + 1);
    localparam logic [CW-1:0] WAIT_LAST = CW'(START_DLY - 1);
    localparam logic [CW-1:0] CONV_LAST = CW'(CONV_CYC - 1);

    seq_state_e    state_q;
    logic [CW-1:0] cnt_q;
    logic          eoc_q, ch_q, ovr_q, smp_prev_q;
    logic          req, standby;

    assign standby = stby_s;
    assign req     = !cs_s && smp_prev_q && !smp_s;
    assign done    = !standby && (state_q == ST_CONV) && (cnt_q == CONV_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            cnt_q      <= '0;
            eoc_q      <= 1'b1;
            ch_q       <= 1'b0;
            ovr_q      <= 1'b0;
            smp_prev_q <= 1'b1;
        end else begin
            smp_prev_q <= smp_s;
            if (standby) begin
                state_q <= ST_IDLE;
                cnt_q   <= '0;
                eoc_q   <= 1'b1;
            end else begin
                if (req && state_q != ST_IDLE) ovr_q <= 1'b1;
                unique case (state_q)
                    ST_IDLE: if (req) begin
                        state_q <= ST_WAIT;
                        cnt_q   <= '0;
                    end
                    ST_WAIT: if (cnt_q == WAIT_LAST) begin
                        state_q <= ST_CONV;
                        cnt_q   <= '0;
                        eoc_q   <= 1'b0;
                        ch_q    <= sel_s;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                    ST_CONV: if (cnt_q == CONV_LAST) begin
                        state_q <= ST_IDLE;
                        cnt_q   <= '0;
                        eoc_q   <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign eoc     = eoc_q;
    assign mux_ch  = ch_q;
    assign overrun = ovr_q;

    p_stby_eoc_r8: assert property (@(posedge clk) disable iff (rst)
        standby |=> eoc_q);
    p_ovr_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        ovr_q |=> ovr_q);
    p_ch_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!eoc_q && $past(!eoc_q)) |-> $stable(ch_q));
    p_idle_high_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_CONV) |-> eoc_q);
endmodule

// File: rtl/sadc_out.sv
module sadc_out
    import sadc_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_s,
    input  logic              rd_s,
    input  logic              oe_s,
    input  logic              eoc,
    input  logic              done,
    input  logic [CODE_W-1:0] core_code,
    output logic [CODE_W-1:0] dout,
    output logic              dout_en,
    output logic              int_n
);
    logic [CODE_W-1:0] data_q;
    logic              pend_q;
    logic              rd_act;

    assign rd_act = !cs_s && !rd_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            pend_q <= 1'b0;
        end else begin
            if (done) data_q <= core_code;
            if (rd_act)    pend_q <= 1'b0;
            else if (done) pend_q <= 1'b1;
        end
    end

    assign dout    = data_q;
    assign dout_en = oe_s && rd_act && eoc;
    assign int_n   = !pend_q;

    p_int_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        $past(rd_act) |-> !pend_q);
    p_data_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (eoc && $past(eoc)) |-> $stable(data_q));
    p_bus_gate_r5: assert property (@(posedge clk) disable iff (rst)
        !eoc |-> !dout_en);
endmodule

// File: rtl/sadc_ctrl.sv
module sadc_ctrl
    import sadc_pkg::*;
#(
    parameter int CODE_W      = 12,
    parameter int SYNC_STAGES = 2,
    parameter int START_DLY   = 3,
    parameter int CONV_CYC    = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              oe,
    input  logic              smp_req_n,
    input  logic              stby_n,
    input  logic              ch_sel,
    input  logic [CODE_W-1:0] core_code,
    output logic              eoc,
    output logic              int_n,
    output logic [CODE_W-1:0] dout,
    output logic              dout_en,
    output logic              mux_ch,
    output logic              overrun
);
    ctl_pins_t pins_raw, pins_s;
    logic      done;

    assign pins_raw = '{cs_n: cs_n, rd_n: rd_n, oe: oe, smp_n: smp_req_n,
                        stby_n: stby_n, sel: ch_sel};

    sadc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .raw(pins_raw), .synced(pins_s)
    );

    sadc_seq #(.START_DLY(START_DLY), .CONV_CYC(CONV_CYC)) u_seq (
        .clk(clk), .rst(rst),
        .cs_s(pins_s.cs_n), .smp_s(pins_s.smp_n), .stby_s(!pins_s.stby_n),
        .sel_s(pins_s.sel),
        .eoc(eoc), .done(done), .mux_ch(mux_ch), .overrun(overrun)
    );

    sadc_out #(.CODE_W(CODE_W)) u_out (
        .clk(clk), .rst(rst),
        .cs_s(pins_s.cs_n), .rd_s(pins_s.rd_n), .oe_s(pins_s.oe),
        .eoc(eoc), .done(done), .core_code(core_code),
        .dout(dout), .dout_en(dout_en), .int_n(int_n)
    );
endmodule

// File: tb/sadc_ctrl_tb_top.sv
module sadc_ctrl_tb_top;
    localparam int CW = 12;
    localparam int SY = 2;
    localparam int SD = 3;
    localparam int CC = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, rd_n = 1'b1, oe = 1'b0, smp_req_n = 1'b1, stby_n = 1'b1, ch_sel = 1'b0;
    logic [CW-1:0] core_code = '0;
    logic eoc, int_n, dout_en, mux_ch, overrun;
    logic [CW-1:0] dout;

    always #2.5 clk = ~clk;

    sadc_ctrl #(.CODE_W(CW), .SYNC_STAGES(SY), .START_DLY(SD), .CONV_CYC(CC)) dut_i (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .oe(oe), .smp_req_n(smp_req_n),
        .stby_n(stby_n), .ch_sel(ch_sel), .core_code(core_code),
        .eoc(eoc), .int_n(int_n), .dout(dout), .dout_en(dout_en),
        .mux_ch(mux_ch), .overrun(overrun)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit first_cmp = 1'b1;

    // pin vector: [5]cs_n [4]rd_n [3]oe [2]smp_req_n [1]stby_n [0]ch_sel
    localparam logic [5:0] IDLE_PINS = 6'b110110;
    logic [5:0] hist[$];
    int m_state, m_cnt;
    bit m_eoc, m_pend, m_ch, m_ovr;
    logic [CW-1:0] m_data;

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            hist.delete();
            for (int i = 0; i < SY + 3; i++) hist.push_back(IDLE_PINS);
            m_state = 0; m_cnt = 0; m_eoc = 1; m_pend = 0; m_ch = 0; m_ovr = 0; m_data = '0;
        end else begin
            logic [5:0] cur, prv;
            bit act, rdact, fall, fin;
            hist.push_front({cs_n, rd_n, oe, smp_req_n, stby_n, ch_sel});
            void'(hist.pop_back());
            cur = hist[SY]; prv = hist[SY+1];
            act = !cur[5]; rdact = act && !cur[4];
            fall = act && prv[2] && !cur[2];
            fin = 0;
            if (!cur[1]) begin
                m_state = 0; m_cnt = 0; m_eoc = 1;
            end else begin
                if (fall && m_state != 0) m_ovr = 1;
                if (m_state == 0) begin
                    if (fall) begin m_state = 1; m_cnt = 0; end
                end else if (m_state == 1) begin
                    if (m_cnt == SD - 1) begin m_state = 2; m_cnt = 0; m_eoc = 0; m_ch = cur[0]; end
                    else m_cnt++;
                end else begin
                    if (m_cnt == CC - 1) begin m_state = 0; m_cnt = 0; m_eoc = 1; m_data = core_code; fin = 1; end
                    else m_cnt++;
                end
            end
            if (rdact) m_pend = 0; else if (fin) m_pend = 1;
        end
    end

    task automatic check1(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %h expected %h", req, cyc, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            logic [5:0] vis;
            bit exp_en;
            vis = hist[SY-1];
            exp_en = vis[3] && !vis[5] && !vis[4] && m_eoc;
            if (first_cmp) begin
                check1("R1 reset eoc", CW'(eoc), CW'(1));
                check1("R1 reset int_n", CW'(int_n), CW'(1));
                check1("R1 reset dout_en", CW'(dout_en), CW'(0));
                check1("R1 reset dout", dout, '0);
                check1("R1 reset mux_ch", CW'(mux_ch), CW'(0));
                check1("R1 reset overrun", CW'(overrun), CW'(0));
                first_cmp = 1'b0;
            end
            check1("R2 R3 R8 eoc", CW'(eoc), CW'(m_eoc));
            check1("R4 int_n", CW'(int_n), CW'(!m_pend));
            check1("R5 dout_en", CW'(dout_en), CW'(exp_en));
            check1("R3 R6 dout", dout, m_data);
            check1("R7 mux_ch", CW'(mux_ch), CW'(m_ch));
            check1("R9 overrun", CW'(overrun), CW'(m_ovr));
        end
    end

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic pulse_req();
        smp_req_n = 1'b0; wait_cyc(2);
        smp_req_n = 1'b1; wait_cyc(1);
    endtask

    task automatic convert(input logic [CW-1:0] code, input logic sel);
        core_code = code; ch_sel = sel;
        pulse_req();
        wait_cyc(SY + SD + CC + 4);
    endtask

    initial begin
        wait_cyc(4);
        rst = 1'b0;
        wait_cyc(3);
        // R2: request with chip deselected is ignored
        pulse_req(); wait_cyc(SY + SD + CC + 4);
        // R6 streaming mode, R7 both channel values
        cs_n = 0; rd_n = 0; oe = 1;
        convert(12'hA5C, 1'b0);
        convert(12'h3F1, 1'b1);
        check1("R3 streamed result", dout, 12'h3F1);
        convert(12'hFFF, 1'b0);
        // R5: enable low hides the bus
        oe = 0; wait_cyc(4); oe = 1; wait_cyc(4);
        // R4: interrupt mode
        rd_n = 1;
        convert(12'h123, 1'b1);
        check1("R4 int pending", CW'(int_n), CW'(0));
        rd_n = 0; wait_cyc(6);
        convert(12'h456, 1'b0);   // R4: read held low keeps int_n high
        check1("R4 int held high", CW'(int_n), CW'(1));
        rd_n = 1; cs_n = 1; wait_cyc(3); cs_n = 0;
        convert(12'h789, 1'b1);
        cs_n = 1; rd_n = 0; wait_cyc(6);   // read without select does not clear
        check1("R4 int needs select", CW'(int_n), CW'(0));
        cs_n = 0; wait_cyc(6);
        // R9: request during conversion
        core_code = 12'h0F0;
        pulse_req(); wait_cyc(SY + SD + 2);
        core_code = 12'h0F0; pulse_req();
        wait_cyc(SY + SD + CC + 6);
        check1("R9 overrun set", CW'(overrun), CW'(1));
        // R8: standby aborts and ignores requests
        core_code = 12'h555; pulse_req(); wait_cyc(SY + SD + 3);
        stby_n = 0; wait_cyc(4);
        pulse_req(); wait_cyc(SY + SD + CC + 4);
        check1("R8 standby eoc high", CW'(eoc), CW'(1));
        check1("R8 result kept", dout, 12'h0F0);
        stby_n = 1; wait_cyc(4);
        convert(12'h2AB, 1'b0);
        wait_cyc(5);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #100000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule